// File: doc/BRIEF.md
# Windowed Input Time Accumulator

This timer channel measures how long one input signal rests at a chosen level inside a programmable interval. A free-running timebase, generated outside the block, is compared every cycle against two programmed values: an opening value and a closing value. When the timebase reaches the opening value the accumulator is zeroed and armed. From then on it advances by one on each prescaled tick in which the synchronized input equals the selected polarity.

When the timebase reaches the closing value, counting stops and the accumulated figure is copied into a separate result register. A sticky event flag is raised at the same moment. Software reads the result at any time and gets the last complete measurement. The live accumulator can also be read, but it is final only outside the window.

Configuration and readback go through a small synchronous register bus. Reads are combinational from the address. Writes are sampled on the rising clock edge.

Top module: `win_time_acc`

## Requirements
- R1: After reset, every readable location (addresses 0 to 5) returns zero and `flag_o` is low.
- R2: The register map is as follows. Address 0 holds the opening value and address 1 the closing value; both are read/write. Address 2 holds the read/write control word, with bit 0 as the polarity and bits 2:1 as the prescaler select. Address 3 is the status word, with bit 0 as the flag. Address 4 returns the live accumulator and address 5 returns the result; both are read-only.
- R3: A cycle in which the timebase equals the opening value clears the accumulator and arms it. A cycle in which it equals the closing value disarms it. With a timebase that rises by one per cycle from opening value S to closing value E, the accumulator may advance only in the E-S-1 cycles strictly between the two matches. The live value is readable during the window.
- R4: While armed, the accumulator advances only when the two-flop-synchronized input equals the polarity bit. Otherwise it holds.
- R5: Prescaler select p permits one increment per p+1 cycles, with the phase restarted at the opening match. A window of n counting cycles at the matching level yields floor(n/(p+1)).
- R6: At the closing match, the result register takes the accumulator value and the flag is set.
- R7: The result register changes only at a closing match. It keeps the previous measurement while a later window is in progress.
- R8: The accumulator saturates at its all-ones value and never wraps.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. When a clear and a closing match fall in the same cycle, the flag stays set.
- R10: When the opening and closing values match in the same cycle, only the closing action takes place: the accumulator is neither cleared nor armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timebase | input | TB_W | External free-running timebase value |
| sig_in | input | 1 | Asynchronous input being measured |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| flag_o | output | 1 | Sticky end-of-window flag |

## Verification
The bench builds the block with an 8-bit timebase and a 5-bit accumulator. The narrow accumulator lets a window of a few dozen cycles drive it into saturation. The narrow timebase keeps every sweep short while the opening and closing values are still placed freely. The bench drives the timebase directly, cycle by cycle, rather than letting it run free. This makes coincident matches, a clear arriving in the same cycle as a closing match, and mid-window reads land on exact cycles.

// File: rtl/wta_pkg.sv
package wta_pkg;

  localparam int ADDR_W = 3;
  localparam int PRE_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_OPEN   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CLOSE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_LIVE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RESULT = 3'd5;

  // control word: bits [2:1] prescaler select, bit 0 polarity
  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             pol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_COUNT = 2'd2,
    ACT_STOP  = 2'd3
  } acc_act_e;

  // a tick is issued when the phase counter reaches the select value
  function automatic logic presc_tick(input logic [PRE_W-1:0] phase,
                                      input logic [PRE_W-1:0] sel);
    return phase == sel;
  endfunction

  function automatic logic [PRE_W-1:0] presc_next(input logic [PRE_W-1:0] phase,
                                                  input logic [PRE_W-1:0] sel);
    if (presc_tick(phase, sel)) return '0;
    return phase + PRE_W'(1);
  endfunction

  // closing match outranks opening match, which outranks counting
  function automatic acc_act_e acc_action(input logic open_hit,
                                          input logic close_hit,
                                          input logic count_ok);
    if (close_hit) return ACT_STOP;
    if (open_hit)  return ACT_CLEAR;
    if (count_ok)  return ACT_COUNT;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/wta_sync.sv
module wta_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/wta_prescaler.sv
module wta_prescaler
  import wta_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q;

  assign tick = presc_tick(phase_q, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= presc_next(phase_q, sel);
  end

  // after a restart the first tick comes at once only for the fastest rate
  assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart && $stable(sel) |=> (tick == (sel == '0)));

endmodule

// File: rtl/wta_window_ctl.sv
module wta_window_ctl #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] timebase,
  input  logic [TB_W-1:0] open_val,
  input  logic [TB_W-1:0] close_val,
  input  logic            flag_clr,
  output logic            open_hit,
  output logic            close_hit,
  output logic            armed,
  output logic            flag
);

  assign open_hit  = (timebase == open_val);
  assign close_hit = (timebase == close_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (close_hit) armed <= 1'b0;
    else if (open_hit)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (close_hit) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  assert_arm_on_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit && !close_hit |=> armed);

  assert_disarm_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    close_hit |=> !armed);

  assert_tie_no_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit && close_hit |=> !armed);

  assert_flag_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_hit |=> flag);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !close_hit |=> !flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

endmodule

// File: rtl/wta_accum.sv
module wta_accum
  import wta_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_hit,
  input  logic             close_hit,
  input  logic             armed,
  input  logic             tick,
  input  logic             level,
  input  logic             pol,
  output logic [ACC_W-1:0] live,
  output logic [ACC_W-1:0] result
);

  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic     level_match;
  logic     sat_hit;
  logic     count_ok;
  acc_act_e act;

  assign level_match = (level == pol);
  assign sat_hit     = (live == ACC_MAX);
  assign count_ok    = armed && tick && level_match && !sat_hit;
  assign act         = acc_action(open_hit, close_hit, count_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= '0;
      result <= '0;
    end else begin
      case (act)
        ACT_STOP:  result <= live;
        ACT_CLEAR: live   <= '0;
        ACT_COUNT: live   <= live + ACC_W'(1);
        default:   ;
      endcase
    end
  end

  assert_clear_on_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit && !close_hit |=> live == '0);

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !open_hit |=> $stable(live));

  assert_level_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !open_hit && !level_match |=> $stable(live));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !open_hit |=> (live == $past(live)) || (live == $past(live) + ACC_W'(1)));

  assert_copy_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_hit |=> result == $past(live));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !close_hit |=> $stable(result));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit && !open_hit |=> live == ACC_MAX);

endmodule

// File: rtl/wta_regs.sv
module wta_regs
  import wta_pkg::*;
#(
  parameter int TB_W   = 16,
  parameter int ACC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ACC_W-1:0]  live,
  input  logic [ACC_W-1:0]  result,
  input  logic              flag,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [TB_W-1:0]   open_val,
  output logic [TB_W-1:0]   close_val,
  output ctrl_t             ctrl,
  output logic              flag_clr
);

  logic wr_open, wr_close, wr_ctrl;

  assign wr_open  = bus_wr && (bus_addr == ADR_OPEN);
  assign wr_close = bus_wr && (bus_addr == ADR_CLOSE);
  assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
  assign flag_clr = bus_wr && (bus_addr == ADR_STATUS) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_val  <= '0;
      close_val <= '0;
      ctrl      <= '0;
    end else begin
      if (wr_open)  open_val  <= bus_wdata[TB_W-1:0];
      if (wr_close) close_val <= bus_wdata[TB_W-1:0];
      if (wr_ctrl)  ctrl      <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_OPEN:   bus_rdata = DATA_W'(open_val);
      ADR_CLOSE:  bus_rdata = DATA_W'(close_val);
      ADR_CTRL:   bus_rdata = DATA_W'(ctrl);
      ADR_STATUS: bus_rdata = DATA_W'(flag);
      ADR_LIVE:   bus_rdata = DATA_W'(live);
      ADR_RESULT: bus_rdata = DATA_W'(result);
      default:    bus_rdata = '0;
    endcase
  end

  assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |=> open_val == $past(bus_wdata[TB_W-1:0]));

endmodule

// File: rtl/win_time_acc.sv
module win_time_acc
  import wta_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int ACC_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TB_W-1:0]   timebase,
  input  logic              sig_in,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              flag_o
);

  logic              level;
  logic              tick;
  logic              open_hit, close_hit, armed, flag, flag_clr;
  logic [TB_W-1:0]   open_val, close_val;
  logic [ACC_W-1:0]  live, result;
  ctrl_t             ctrl;

  wta_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .dout(level)
  );

  wta_regs #(.TB_W(TB_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .live(live), .result(result), .flag(flag),
    .bus_rdata(bus_rdata),
    .open_val(open_val), .close_val(close_val), .ctrl(ctrl), .flag_clr(flag_clr)
  );

  wta_window_ctl #(.TB_W(TB_W)) u_window (
    .clk(clk), .rst_n(rst_n), .timebase(timebase),
    .open_val(open_val), .close_val(close_val), .flag_clr(flag_clr),
    .open_hit(open_hit), .close_hit(close_hit), .armed(armed), .flag(flag)
  );

  wta_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .restart(open_hit), .sel(ctrl.presc), .tick(tick)
  );

  wta_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .open_hit(open_hit), .close_hit(close_hit), .armed(armed),
    .tick(tick), .level(level), .pol(ctrl.pol),
    .live(live), .result(result)
  );

  assign flag_o = flag;

  initial begin
    assert (DATA_W >= TB_W && DATA_W >= ACC_W && DATA_W >= CTRL_W)
      else $error("DATA_W too narrow for register contents (R2)");
  end

endmodule

// File: tb/win_time_acc_bench.sv
module win_time_acc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_W   = 8;
  localparam int ACC_W  = 5;
  localparam int DATA_W = 8;

  // opening, closing, polarity, prescaler, input level, expected result
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{10, 30, 1, 0, 1, 19},
    '{ 5, 25, 1, 1, 1,  9},
    '{20, 45, 0, 2, 0,  8},
    '{ 8, 30, 1, 3, 1,  5},
    '{12, 40, 1, 0, 0,  0},
    '{ 3, 20, 0, 0, 1,  0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TB_W-1:0]   timebase = TB_W'(200);
  logic              sig_in = 1'b0;
  logic              bus_wr = 1'b0;
  logic [2:0]        bus_addr = 3'd0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              flag_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] rv;

  win_time_acc #(.TB_W(TB_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) u_win_time_acc (
    .clk(clk), .rst_n(rst_n), .timebase(timebase), .sig_in(sig_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input int exp);
    n_chk++;
    if (act !== 32'(exp)) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // combinational read without advancing the clock
  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    bus_addr = 3'(a);
    #1;
    v = bus_rdata;
  endtask

  task automatic sweep(input int from_v, input int to_v);
    for (int i = from_v; i <= to_v; i++) begin
      @(negedge clk);
      timebase = TB_W'(i);
    end
  endtask

  task automatic setup(input int s, input int e, input int pol, input int p);
    wr(0, s);
    wr(1, e);
    wr(2, (p << 1) | pol);
    wr(3, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every readable location and the flag
    rd(0, rv); check("R1 open", rv, 0);
    rd(1, rv); check("R1 close", rv, 0);
    rd(2, rv); check("R1 ctrl", rv, 0);
    @(negedge clk);
    rd(3, rv); check("R1 status", rv, 0);
    rd(4, rv); check("R1 live", rv, 0);
    rd(5, rv); check("R1 result", rv, 0);
    check("R1 flag_o", flag_o, 0);

    // R3 R4 R5 R6: table of windows
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      if (v == 0) begin
        rd(0, rv); check("R2 open readback", rv, VEC[v][0]);
        rd(1, rv); check("R2 close readback", rv, VEC[v][1]);
        rd(2, rv); check("R2 ctrl readback", rv, (VEC[v][3] << 1) | VEC[v][2]);
        @(negedge clk);
        rd(3, rv); check("R9 flag cleared by write 1", rv, 0);
      end
      sig_in = VEC[v][4][0];
      sweep(VEC[v][0] - 2, VEC[v][1] + 2);
      rd(5, rv); check($sformatf("R5 R4 result vec %0d", v), rv, VEC[v][5]);
      rd(4, rv); check($sformatf("R3 live after window vec %0d", v), rv, VEC[v][5]);
      check($sformatf("R6 flag vec %0d", v), flag_o, 1);
    end

    // R8: long window saturates at 31
    setup(2, 60, 1, 0);
    sig_in = 1'b1;
    sweep(0, 62);
    rd(5, rv); check("R8 saturated result", rv, 31);
    rd(4, rv); check("R8 saturated live", rv, 31);

    // R7: result holds mid-window, live is in progress
    setup(10, 30, 1, 0);
    sweep(8, 20);
    rd(5, rv); check("R7 result held mid-window", rv, 31);
    rd(4, rv); check("R3 live mid-window", rv, 9);
    check("R7 flag low mid-window", flag_o, 0);
    sweep(21, 32);
    rd(5, rv); check("R6 result after window", rv, 19);

    // R9: writing 0 has no effect, writing 1 clears
    wr(3, 0);
    check("R9 write 0 keeps flag", flag_o, 1);
    wr(3, 1);
    check("R9 write 1 clears flag", flag_o, 0);

    // R9: clear coinciding with closing match, set wins
    wr(1, 25);
    sweep(8, 24);
    @(negedge clk);
    timebase = TB_W'(25);
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = DATA_W'(1);
    @(negedge clk);
    bus_wr = 1'b0;
    timebase = TB_W'(26);
    check("R9 set wins over clear", flag_o, 1);
    rd(5, rv); check("R6 result window 10..25", rv, 14);

    // R10: opening and closing coincide
    wr(3, 1);
    wr(0, 50);
    wr(1, 50);
    check("R10 flag low before tie", flag_o, 0);
    sweep(48, 52);
    check("R10 tie sets flag", flag_o, 1);
    rd(5, rv); check("R10 result copied", rv, 14);
    rd(4, rv); check("R10 live not cleared", rv, 14);
    @(negedge clk);
    @(negedge clk);
    rd(4, rv); check("R10 not armed after tie", rv, 14);

    finish_run();
  end

endmodule